// File: doc/BRIEF.md
# Legacy IO Window Bridge

This block lets a processor reach a 16-bit legacy IO port bus through a fixed 64 KB window of its physical address space. A load or store whose address lands in the window becomes exactly one port cycle. The port address is the access address cut down to its low 16 bits, and the access size (byte, halfword or word) is passed on with it.

The processor side uses a request/acknowledge handshake. The requester raises `cpu_valid` together with the address, size, direction and write data, and holds them until `cpu_ready` pulses. The port side holds `io_valid` and its fields steady until the peripheral answers with `io_ready`.

A parameter selects a big-endian processor. In that mode halfword and word data are byte-reversed in both directions. Byte data is never reordered. Data lanes the access size does not cover are driven as zero.

Top module: `io_window_bridge`

## Requirements
- R1: `cpu_claim` is high exactly when `cpu_addr` lies in 0x7000_0000 to 0x7000_FFFF inclusive.
- R2: A request outside the window is not claimed. It starts no port cycle and never receives `cpu_ready`.
- R3: The port cycle carries `io_addr` equal to `cpu_addr[15:0]`, the request's direction on `io_write`, and the size on `io_size` (0 = byte, 1 = halfword, 2 = word).
- R4: Each claimed request gives exactly one port cycle. `io_valid` and all port fields stay unchanged until the cycle in which `io_ready` is sampled high, whatever the wait-state count.
- R5: `cpu_ready` is a single-cycle pulse. It comes in the clock cycle after the port handshake, and `cpu_rdata` holds the read result during that pulse.
- R6: Byte accesses use lane 0 (bits 7:0) unreordered in both modes. Write bits 31:8 on `io_wdata` and read bits 31:8 on `cpu_rdata` are zero.
- R7: In big-endian mode a halfword write sends `{wdata[7:0], wdata[15:8]}` on `io_wdata[15:0]`. A halfword read returns `{io_rdata[7:0], io_rdata[15:8]}` on `cpu_rdata[15:0]`. Bits 31:16 are zero in both directions.
- R8: In big-endian mode a word access reverses all four bytes in both directions (byte 0 becomes byte 3, byte 1 becomes byte 2).
- R9: With the big-endian parameter off, halfword and word data pass through in lane order, with the unused upper lanes zeroed.
- R10: While reset is asserted, and in the first cycle after it, `io_valid` and `cpu_ready` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_valid | input | 1 | Processor request present |
| cpu_addr | input | 32 | Processor physical address |
| cpu_write | input | 1 | 1 = store, 0 = load |
| cpu_size | input | 2 | 0 byte, 1 halfword, 2 word |
| cpu_wdata | input | 32 | Store data, processor lane order |
| cpu_claim | output | 1 | Address falls in the window |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 32 | Load result, valid with cpu_ready |
| io_valid | output | 1 | Port cycle in progress |
| io_ready | input | 1 | Peripheral completes the port cycle |
| io_addr | output | 16 | Port address |
| io_size | output | 2 | Port access size |
| io_write | output | 1 | Port cycle direction |
| io_wdata | output | 32 | Port write data, bus lane order |
| io_rdata | input | 32 | Port read data, bus lane order |

## Verification
A table of accesses covers each size in both directions. The data uses a distinct byte in every lane, so a swap, a missing swap, a wrong reversal order or a stale upper lane each give a different wrong value. The same requests go to a big-endian and a little-endian instance in lockstep, which separates mode-dependent steering from plain passthrough. Addresses just below and just above the window test the decode edges, and the first and last port addresses test the truncation. A run with several wait states, and back-to-back requests, check that exactly one port cycle happens per access.

// File: rtl/iowb_pkg.sv
// Shared types for the IO window bridge.
// Assumes a 2-bit size code; code 3 is treated like a word.
package iowb_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2
    } xfer_size_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PORT = 2'd1,
        ST_DONE = 2'd2
    } seq_state_e;
endpackage

// File: rtl/iowb_window_decode.sv
// Window decode: flags addresses whose upper bits match the window base
// and yields the truncated port address.
// Assumes the window size is 2**PORT_AW and the base is aligned to it.
module iowb_window_decode #(
    parameter int                ADDR_W   = 32,
    parameter int                PORT_AW  = 16,
    parameter logic [ADDR_W-1:0] WIN_BASE = 32'h7000_0000
) (
    input  logic [ADDR_W-1:0]  addr,
    output logic               hit,
    output logic [PORT_AW-1:0] port_addr
);
    localparam int TAG_W = ADDR_W - PORT_AW;
    localparam logic [TAG_W-1:0] BASE_TAG = WIN_BASE[ADDR_W-1:PORT_AW];

    // Compare the tag bits and pass the offset through.
    always_comb begin
        hit       = (addr[ADDR_W-1:PORT_AW] == BASE_TAG);
        port_addr = addr[PORT_AW-1:0];
    end
endmodule

// File: rtl/iowb_lane_steer.sv
// Lane steering: keeps only the bytes an access size covers. In big-endian
// mode it reverses their order. Used on both the write and the read path.
// Assumes DATA_W is a whole number of bytes and at least 32 bits.
module iowb_lane_steer #(
    parameter int DATA_W     = 32,
    parameter bit BIG_ENDIAN = 1'b1
) (
    input  logic [DATA_W-1:0] din,
    input  logic [1:0]        size,
    output logic [DATA_W-1:0] dout
);
    import iowb_pkg::*;
    localparam int LANES = DATA_W / 8;

    int nbytes;

    // Number of active lanes for this size.
    always_comb begin
        case (xfer_size_e'(size))
            SZ_BYTE: nbytes = 1;
            SZ_HALF: nbytes = 2;
            default: nbytes = 4;
        endcase
    end

    generate
        if (BIG_ENDIAN) begin : g_be
            // Reverse the active lanes, zero the rest.
            always_comb begin
                dout = '0;
                for (int i = 0; i < LANES; i++) begin
                    if (i < nbytes)
                        dout[8*i +: 8] = din[8*(nbytes-1-i) +: 8];
                end
            end
        end else begin : g_le
            // Keep the active lanes in place, zero the rest.
            always_comb begin
                dout = '0;
                for (int i = 0; i < LANES; i++) begin
                    if (i < nbytes)
                        dout[8*i +: 8] = din[8*i +: 8];
                end
            end
        end
    endgenerate
endmodule

// File: rtl/iowb_port_seq.sv
// Port sequencer: takes one claimed request, holds a port cycle until the
// peripheral acknowledges, then gives a one-cycle completion pulse.
// Assumes the requester holds its request until the completion pulse.
module iowb_port_seq #(
    parameter int DATA_W  = 32,
    parameter int PORT_AW = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [PORT_AW-1:0] req_addr,
    input  logic [1:0]         req_size,
    input  logic               req_write,
    input  logic [DATA_W-1:0]  req_wdata,
    input  logic               io_ready,
    input  logic [DATA_W-1:0]  rd_steered,
    output logic               io_valid,
    output logic [PORT_AW-1:0] io_addr,
    output logic [1:0]         io_size,
    output logic               io_write,
    output logic [DATA_W-1:0]  io_wdata,
    output logic               done,
    output logic [DATA_W-1:0]  rdata
);
    import iowb_pkg::*;

    seq_state_e         state;
    logic [PORT_AW-1:0] addr_q;
    logic [1:0]         size_q;
    logic               write_q;
    logic [DATA_W-1:0]  wdata_q;
    logic [DATA_W-1:0]  rdata_q;

    // State machine: idle, port cycle, completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            case (state)
                ST_IDLE: if (start)    state <= ST_PORT;
                ST_PORT: if (io_ready) state <= ST_DONE;
                default:               state <= ST_IDLE;
            endcase
        end
    end

    // Capture the request fields when a port cycle starts.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            size_q  <= '0;
            write_q <= 1'b0;
            wdata_q <= '0;
        end else if (state == ST_IDLE && start) begin
            addr_q  <= req_addr;
            size_q  <= req_size;
            write_q <= req_write;
            wdata_q <= req_wdata;
        end
    end

    // Capture the steered read data at the handshake; writes return zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata_q <= '0;
        else if (state == ST_PORT && io_ready)
            rdata_q <= write_q ? '0 : rd_steered;
    end

    // Drive the outputs from state and captured fields.
    always_comb begin
        io_valid = (state == ST_PORT);
        done     = (state == ST_DONE);
        io_addr  = addr_q;
        io_size  = size_q;
        io_write = write_q;
        io_wdata = wdata_q;
        rdata    = rdata_q;
    end
endmodule

// File: rtl/io_window_bridge.sv
// IO window bridge top: decodes the window, steers write lanes before
// capture and read lanes at the handshake, and runs one port cycle per
// claimed request.
// Assumes one outstanding request at a time.
module io_window_bridge #(
    parameter int                ADDR_W     = 32,
    parameter int                DATA_W     = 32,
    parameter int                PORT_AW    = 16,
    parameter logic [ADDR_W-1:0] WIN_BASE   = 32'h7000_0000,
    parameter bit                BIG_ENDIAN = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cpu_valid,
    input  logic [ADDR_W-1:0]  cpu_addr,
    input  logic               cpu_write,
    input  logic [1:0]         cpu_size,
    input  logic [DATA_W-1:0]  cpu_wdata,
    output logic               cpu_claim,
    output logic               cpu_ready,
    output logic [DATA_W-1:0]  cpu_rdata,
    output logic               io_valid,
    input  logic               io_ready,
    output logic [PORT_AW-1:0] io_addr,
    output logic [1:0]         io_size,
    output logic               io_write,
    output logic [DATA_W-1:0]  io_wdata,
    input  logic [DATA_W-1:0]  io_rdata
);
    logic               hit;
    logic [PORT_AW-1:0] port_addr;
    logic [DATA_W-1:0]  wr_steered;
    logic [DATA_W-1:0]  rd_steered;

    iowb_window_decode #(
        .ADDR_W(ADDR_W), .PORT_AW(PORT_AW), .WIN_BASE(WIN_BASE)
    ) u_decode (
        .addr(cpu_addr), .hit(hit), .port_addr(port_addr)
    );

    iowb_lane_steer #(
        .DATA_W(DATA_W), .BIG_ENDIAN(BIG_ENDIAN)
    ) u_wr_steer (
        .din(cpu_wdata), .size(cpu_size), .dout(wr_steered)
    );

    iowb_lane_steer #(
        .DATA_W(DATA_W), .BIG_ENDIAN(BIG_ENDIAN)
    ) u_rd_steer (
        .din(io_rdata), .size(io_size), .dout(rd_steered)
    );

    iowb_port_seq #(
        .DATA_W(DATA_W), .PORT_AW(PORT_AW)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .start(cpu_valid && hit),
        .req_addr(port_addr), .req_size(cpu_size),
        .req_write(cpu_write), .req_wdata(wr_steered),
        .io_ready(io_ready), .rd_steered(rd_steered),
        .io_valid(io_valid), .io_addr(io_addr), .io_size(io_size),
        .io_write(io_write), .io_wdata(io_wdata),
        .done(cpu_ready), .rdata(cpu_rdata)
    );

    // Expose the window decode to the requester.
    always_comb cpu_claim = hit;
endmodule

// File: rtl/io_window_bridge_checker.sv
// Protocol checker for the IO window bridge, attached by bind.
// Assumes requesters keep their request steady until the completion pulse.
module io_window_bridge_checker #(
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 32,
    parameter int PORT_AW = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               cpu_valid,
    input logic [ADDR_W-1:0]  cpu_addr,
    input logic               cpu_claim,
    input logic               cpu_ready,
    input logic               io_valid,
    input logic               io_ready,
    input logic [PORT_AW-1:0] io_addr,
    input logic [1:0]         io_size,
    input logic               io_write,
    input logic [DATA_W-1:0]  io_wdata
);
    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        io_valid && !io_ready |=> io_valid && $stable(io_addr) &&
        $stable(io_size) && $stable(io_write) && $stable(io_wdata));

    assert_start_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(io_valid) |-> $past(cpu_valid && cpu_claim));

    assert_no_claim_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !io_valid && cpu_valid && !cpu_claim |=> !io_valid);

    assert_addr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(io_valid) |-> io_addr == $past(cpu_addr[PORT_AW-1:0]));

    assert_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |=> !cpu_ready);

    assert_after_hs_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |-> $past(io_valid && io_ready));

    assert_byte_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
        io_valid && io_size == 2'd0 |-> io_wdata[DATA_W-1:8] == '0);

    assert_reset_R10: assert property (@(posedge clk)
        $rose(rst_n) |-> !io_valid && !cpu_ready);
endmodule

bind io_window_bridge io_window_bridge_checker #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PORT_AW(PORT_AW)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_addr(cpu_addr),
    .cpu_claim(cpu_claim), .cpu_ready(cpu_ready), .io_valid(io_valid),
    .io_ready(io_ready), .io_addr(io_addr), .io_size(io_size),
    .io_write(io_write), .io_wdata(io_wdata)
);

// File: tb/io_window_bridge_test.sv
module io_window_bridge_test;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [31:0] addr;
        logic        wr;
        logic [1:0]  sz;
        logic [31:0] wd;
        logic [31:0] prd;
        logic [15:0] pa;
        logic [31:0] be_x;
        logic [31:0] le_x;
    } vec_t;

    localparam int NV = 7;
    localparam vec_t VEC [NV] = '{
        '{32'h7000_03F8, 1'b1, 2'd0, 32'hAABB_CC5A, 32'h0,         16'h03F8, 32'h0000_005A, 32'h0000_005A},
        '{32'h7000_1234, 1'b1, 2'd1, 32'hDEAD_1122, 32'h0,         16'h1234, 32'h0000_2211, 32'h0000_1122},
        '{32'h7000_FFFC, 1'b1, 2'd2, 32'h1122_3344, 32'h0,         16'hFFFC, 32'h4433_2211, 32'h1122_3344},
        '{32'h7000_0060, 1'b0, 2'd0, 32'h0,         32'hFFFF_FF96, 16'h0060, 32'h0000_0096, 32'h0000_0096},
        '{32'h7000_8002, 1'b0, 2'd1, 32'h0,         32'hFFFF_ABCD, 16'h8002, 32'h0000_CDAB, 32'h0000_ABCD},
        '{32'h7000_0000, 1'b0, 2'd2, 32'h0,         32'h0102_0304, 16'h0000, 32'h0403_0201, 32'h0102_0304},
        '{32'h7000_FFFF, 1'b0, 2'd0, 32'h0,         32'h1234_567E, 16'hFFFF, 32'h0000_007E, 32'h0000_007E}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_valid = 1'b0;
    logic [31:0] cpu_addr = '0;
    logic        cpu_write = 1'b0;
    logic [1:0]  cpu_size = '0;
    logic [31:0] cpu_wdata = '0;
    logic        io_ready = 1'b0;
    logic [31:0] io_rdata = '0;

    logic        be_claim, be_ready, be_io_valid, be_io_write;
    logic [31:0] be_rdata, be_io_wdata;
    logic [15:0] be_io_addr;
    logic [1:0]  be_io_size;
    logic        le_claim, le_ready, le_io_valid, le_io_write;
    logic [31:0] le_rdata, le_io_wdata;
    logic [15:0] le_io_addr;
    logic [1:0]  le_io_size;

    io_window_bridge #(.BIG_ENDIAN(1'b1)) uut (
        .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_addr(cpu_addr),
        .cpu_write(cpu_write), .cpu_size(cpu_size), .cpu_wdata(cpu_wdata),
        .cpu_claim(be_claim), .cpu_ready(be_ready), .cpu_rdata(be_rdata),
        .io_valid(be_io_valid), .io_ready(io_ready), .io_addr(be_io_addr),
        .io_size(be_io_size), .io_write(be_io_write), .io_wdata(be_io_wdata),
        .io_rdata(io_rdata)
    );

    io_window_bridge #(.BIG_ENDIAN(1'b0)) uut_le (
        .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_addr(cpu_addr),
        .cpu_write(cpu_write), .cpu_size(cpu_size), .cpu_wdata(cpu_wdata),
        .cpu_claim(le_claim), .cpu_ready(le_ready), .cpu_rdata(le_rdata),
        .io_valid(le_io_valid), .io_ready(io_ready), .io_addr(le_io_addr),
        .io_size(le_io_size), .io_write(le_io_write), .io_wdata(le_io_wdata),
        .io_rdata(io_rdata)
    );

    int checks = 0;
    int errors = 0;
    int port_cycles = 0;
    int ready_pulses = 0;
    int latency = 0;
    int wcnt = 0;
    int cyc = 0;
    logic [31:0] rd_value = '0;
    logic [15:0] seen_addr;
    logic [1:0]  seen_size;
    logic        seen_write;
    logic [31:0] seen_be_wdata, seen_le_wdata;
    logic [31:0] got_be, got_le;

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Port-side peripheral model, driven at the falling edge.
    always @(negedge clk) begin
        if (be_ready) ready_pulses++;
        if (io_ready) begin
            io_ready = 1'b0;
        end else if (be_io_valid) begin
            if (wcnt >= latency) begin
                wcnt = 0;
                io_ready = 1'b1;
                io_rdata = rd_value;
                seen_addr = be_io_addr;
                seen_size = be_io_size;
                seen_write = be_io_write;
                seen_be_wdata = be_io_wdata;
                seen_le_wdata = le_io_wdata;
                port_cycles++;
            end else begin
                wcnt++;
            end
        end
    end

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc == 50000) begin
            errors++;
            $display("FAIL R4 watchdog: actual hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic access(input logic [31:0] a, input logic w, input logic [1:0] s,
                          input logic [31:0] d, input logic [31:0] prd);
        int t;
        @(negedge clk);
        rd_value  = prd;
        cpu_addr  = a;
        cpu_write = w;
        cpu_size  = s;
        cpu_wdata = d;
        cpu_valid = 1'b1;
        t = 0;
        do begin
            @(negedge clk);
            t++;
        end while (!be_ready && t < 100);
        got_be = be_rdata;
        got_le = le_rdata;
        chk(be_ready && le_ready, "R5", "ready pulse", {31'b0, be_ready}, 32'h1);
        cpu_valid = 1'b0;
        @(negedge clk);
        chk(!be_ready, "R5", "ready one cycle", {31'b0, be_ready}, 32'h0);
    endtask

    initial begin
        int pc0;
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(!be_io_valid, "R10", "io_valid in reset", {31'b0, be_io_valid}, 32'h0);
        chk(!be_ready, "R10", "cpu_ready in reset", {31'b0, be_ready}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!be_io_valid && !be_ready, "R10", "idle after reset",
            {30'b0, be_io_valid, be_ready}, 32'h0);

        // Vector table: R3, R6, R7, R8, R9
        for (int i = 0; i < NV; i++) begin
            pc0 = port_cycles;
            access(VEC[i].addr, VEC[i].wr, VEC[i].sz, VEC[i].wd, VEC[i].prd);
            chk(port_cycles == pc0 + 1, "R4", "one port cycle", port_cycles - pc0, 1);
            chk(seen_addr == VEC[i].pa, "R3", "io_addr", {16'b0, seen_addr}, {16'b0, VEC[i].pa});
            chk(seen_size == VEC[i].sz, "R3", "io_size", {30'b0, seen_size}, {30'b0, VEC[i].sz});
            chk(seen_write == VEC[i].wr, "R3", "io_write", {31'b0, seen_write}, {31'b0, VEC[i].wr});
            if (VEC[i].wr) begin
                chk(seen_be_wdata == VEC[i].be_x, VEC[i].sz == 0 ? "R6" : (VEC[i].sz == 1 ? "R7" : "R8"),
                    "be io_wdata", seen_be_wdata, VEC[i].be_x);
                chk(seen_le_wdata == VEC[i].le_x, "R9", "le io_wdata", seen_le_wdata, VEC[i].le_x);
            end else begin
                chk(got_be == VEC[i].be_x, VEC[i].sz == 0 ? "R6" : (VEC[i].sz == 1 ? "R7" : "R8"),
                    "be cpu_rdata", got_be, VEC[i].be_x);
                chk(got_le == VEC[i].le_x, "R9", "le cpu_rdata", got_le, VEC[i].le_x);
            end
        end

        // R1/R2: addresses just outside the window
        for (int k = 0; k < 2; k++) begin
            int rp0;
            pc0 = port_cycles;
            rp0 = ready_pulses;
            @(negedge clk);
            cpu_addr  = (k == 0) ? 32'h6FFF_FFFF : 32'h7001_0000;
            cpu_write = 1'b0;
            cpu_size  = 2'd2;
            cpu_valid = 1'b1;
            @(negedge clk);
            chk(!be_claim, "R1", "claim outside window", {31'b0, be_claim}, 32'h0);
            repeat (20) @(negedge clk);
            chk(port_cycles == pc0, "R2", "no port cycle", port_cycles - pc0, 0);
            chk(ready_pulses == rp0, "R2", "no ready", ready_pulses - rp0, 0);
            cpu_valid = 1'b0;
        end
        cpu_addr = 32'h7000_ABCD;
        @(negedge clk);
        chk(be_claim, "R1", "claim inside window", {31'b0, be_claim}, 32'h1);

        // R4: wait states and back-to-back accesses
        latency = 4;
        pc0 = port_cycles;
        access(32'h7000_0400, 1'b0, 2'd2, 32'h0, 32'hA1B2_C3D4);
        chk(got_be == 32'hD4C3_B2A1, "R8", "word read with wait states", got_be, 32'hD4C3_B2A1);
        access(32'h7000_0402, 1'b1, 2'd1, 32'h0000_5566, 32'h0);
        chk(seen_be_wdata == 32'h0000_6655, "R7", "half write with wait states",
            seen_be_wdata, 32'h0000_6655);
        chk(port_cycles == pc0 + 2, "R4", "two accesses two port cycles", port_cycles - pc0, 2);
        latency = 0;
        access(32'h7000_0404, 1'b1, 2'd0, 32'h0000_00F0, 32'h0);
        chk(got_be == 32'h0, "R5", "write returns zero data", got_be, 32'h0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule